// File: doc/BRIEF.md
# Reloadable 16-bit Interval Timer

A down-counting interval timer that raises an interrupt request each time its count lands on zero. Software reaches it through a small synchronous register bus with three words: a control/status word, a modulus word and a read-only count word. The counter moves one step on each cycle where the external count tick is high and the timer is enabled. What happens after zero depends on the mode. With reload on, the counter takes the modulus and so produces a fixed period. With reload off, it wraps to all-ones and runs freely.

An overwrite option lets a modulus write load the counter at once, so software can restart the period without waiting for zero. The interrupt flag is cleared by writing 1 to its bit. The request line to the CPU is the flag gated by the interrupt-enable bit.

Top module: `ivtimer`

## Requirements
- R1: After reset, the control/status word reads 0, the modulus reads 0xFFFF, the count reads 0xFFFF, and `irq` is low.
- R2: With reload on (control bit 1), a count step taken at 0 loads the modulus. With modulus 3 the count runs 3, 2, 1, 0, 3.
- R3: With reload off, a count step taken at 0 gives 0xFFFF, and the next step gives 0xFFFE.
- R4: Any count step that leaves the counter at 0 sets the flag (control bit 4), in either mode.
- R5: `irq` is high exactly when the flag and interrupt enable (control bit 2) are both set.
- R6: Writing control with bit 4 = 1 clears the flag, and writing bit 4 = 0 leaves it unchanged. If a set event and a clear fall on the same clock edge, the flag ends set.
- R7: With overwrite on (control bit 3), a modulus write loads the counter on the same clock edge that stores the modulus.
- R8: With overwrite off, a modulus write leaves the counter alone, and the new value is first used at the next reload from 0.
- R9: The counter changes only on edges where `tick` is high and enable (control bit 0) is set. Otherwise it holds.
- R10: Writes to the count word (address 2) complete and change nothing.
- R11: The word map is: address 0 holds control/status in bits 4..0 {flag, overwrite, irq enable, reload, enable}; address 1 holds the modulus; address 2 holds the full 16-bit count; address 3 reads 0. Reads are combinational from `bus_sel`, `bus_wr` = 0 and `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable pulse |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
A write or a count step takes effect on the clock edge that samples it. Its result is therefore first visible one cycle later, and reads and `irq` show it with no added delay. The bench applies each stimulus on a falling edge and queues the expected result when it issues the read that follows. The monitor compares a quarter period after that falling edge, which is after the rising edge that applied the previous stimulus and well before the next one. Modulus and control writes that fall between a write and a count step are checked through the count word. The set-versus-clear collision is driven on a single edge.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
   localparam int CTL_EN   = 0;
   localparam int CTL_RLD  = 1;
   localparam int CTL_IE   = 2;
   localparam int CTL_OW   = 3;
   localparam int CTL_FLAG = 4;
   localparam int CTL_BITS = 5;

   typedef enum logic [1:0] {
      A_CTRL  = 2'd0,
      A_MOD   = 2'd1,
      A_COUNT = 2'd2,
      A_NONE  = 2'd3
   } ivt_addr_e;

   typedef struct packed {
      logic flag;
      logic ow;
      logic ie;
      logic rld;
      logic en;
   } ivt_ctl_t;
endpackage

// File: rtl/ivt_counter.sv
module ivt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             rld,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] modv,
   output logic [CNT_W-1:0] cnt,
   output logic             zero_hit
);
   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   logic [CNT_W-1:0] nxt;

   always_comb begin
      if (cnt == '0) nxt = rld ? modv : ALL_ONES;
      else           nxt = cnt - 1'b1;
   end

   assign zero_hit = step && !load && (nxt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= ALL_ONES;
      else if (load) cnt <= load_val;
      else if (step) cnt <= nxt;
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(cnt)); // R9
   AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && rld && cnt == '0) |=> (cnt == $past(modv))); // R2
   AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !rld && cnt == '0) |=> (cnt == ALL_ONES)); // R3
   AST_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val))); // R7
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
   import ivt_pkg::*;
#(
   parameter int               CNT_W   = 16,
   parameter logic [CNT_W-1:0] RST_MOD = {CNT_W{1'b1}}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic             wr_mod,
   input  logic [CNT_W-1:0] wdata,
   input  logic             set_evt,
   output ivt_ctl_t         ctl,
   output logic [CNT_W-1:0] modv
);
   logic clr_req;
   assign clr_req = wr_ctrl && wdata[CTL_FLAG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl  <= '0;
         modv <= RST_MOD;
      end else begin
         if (wr_ctrl) begin
            ctl.en  <= wdata[CTL_EN];
            ctl.rld <= wdata[CTL_RLD];
            ctl.ie  <= wdata[CTL_IE];
            ctl.ow  <= wdata[CTL_OW];
         end
         if (set_evt)      ctl.flag <= 1'b1;
         else if (clr_req) ctl.flag <= 1'b0;
         if (wr_mod) modv <= wdata;
      end
   end

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> ctl.flag); // R4
   AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !set_evt) |=> !ctl.flag); // R6
   AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_req && !set_evt) |=> $stable(ctl.flag)); // R6
endmodule

// File: rtl/ivtimer.sv
module ivtimer
   import ivt_pkg::*;
#(
   parameter int               CNT_W    = 16,
   parameter int               ADDR_W   = 2,
   parameter logic [CNT_W-1:0] RST_MOD  = {CNT_W{1'b1}},
   parameter bit               READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              irq
);
   localparam int PAD_W = CNT_W - CTL_BITS;

   if (CNT_W < CTL_BITS) begin : g_bad_width
      $error("ivtimer: CNT_W must hold the control word");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ivtimer: ADDR_W must be at least 2");
   end

   ivt_ctl_t         ctl;
   logic [CNT_W-1:0] modv;
   logic [CNT_W-1:0] cnt;
   logic             zero_hit;
   logic             wr_ctrl, wr_mod, rd_en, step, load;
   logic [CNT_W-1:0] rd_mux;

   assign wr_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_W'(A_CTRL));
   assign wr_mod  = bus_sel && bus_wr && (bus_addr == ADDR_W'(A_MOD));
   assign rd_en   = bus_sel && !bus_wr;
   assign step    = tick && ctl.en;
   assign load    = wr_mod && ctl.ow;

   ivt_regs #(.CNT_W(CNT_W), .RST_MOD(RST_MOD)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr_ctrl),
      .wr_mod  (wr_mod),
      .wdata   (bus_wdata),
      .set_evt (zero_hit),
      .ctl     (ctl),
      .modv    (modv)
   );

   ivt_counter #(.CNT_W(CNT_W)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .rld      (ctl.rld),
      .load     (load),
      .load_val (bus_wdata),
      .modv     (modv),
      .cnt      (cnt),
      .zero_hit (zero_hit)
   );

   always_comb begin
      rd_mux = '0;
      if (rd_en) begin
         case (bus_addr)
            ADDR_W'(A_CTRL):  rd_mux = {{PAD_W{1'b0}}, ctl};
            ADDR_W'(A_MOD):   rd_mux = modv;
            ADDR_W'(A_COUNT): rd_mux = cnt;
            default:          rd_mux = '0;
         endcase
      end
   end

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) bus_rdata <= '0;
         else        bus_rdata <= rd_mux;
      end
   end else begin : g_rd_comb
      assign bus_rdata = rd_mux;
   end

   assign irq = ctl.flag && ctl.ie;

   AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !bus_wdata[CTL_IE]) |=> !irq); // R5
   AST_COUNT_RO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(A_COUNT) && !step) |=> $stable(cnt)); // R10
endmodule

// File: tb/ivtimer_bench.sv
module ivtimer_bench;
   localparam int CLK_P = 10;
   localparam int WDOG  = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;

   typedef struct {
      bit          is_irq;
      logic [15:0] exp;
      string       req;
   } item_t;

   item_t sb_q[$];
   int    n_chk = 0;
   int    n_err = 0;
   bit    done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   ivtimer u_ivtimer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic drive(input bit sel, input bit wr, input logic [1:0] a,
                        input logic [15:0] d, input bit tk);
      @(negedge clk);
      bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d; tick = tk;
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      drive(1'b1, 1'b1, a, d, 1'b0);
   endtask

   task automatic step();
      drive(1'b0, 1'b0, 2'd0, 16'h0, 1'b1);
   endtask

   task automatic rd(input logic [1:0] a, input logic [15:0] e, input string req);
      item_t it;
      drive(1'b1, 1'b0, a, 16'h0, 1'b0);
      it.is_irq = 1'b0; it.exp = e; it.req = req;
      sb_q.push_back(it);
   endtask

   task automatic chk_irq(input bit e, input string req);
      item_t it;
      drive(1'b0, 1'b0, 2'd0, 16'h0, 1'b0);
      it.is_irq = 1'b1; it.exp = {15'h0, e}; it.req = req;
      sb_q.push_back(it);
   endtask

   // monitor: compares a quarter period after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         while (sb_q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {15'h0, irq} : bus_rdata;
            n_chk++;
            if (act !== it.exp) begin
               n_err++;
               $display("FAIL %s %s: actual=%h expected=%h", it.req,
                        it.is_irq ? "irq" : "rdata", act, it.exp);
            end
         end
      end
   end

   initial begin
      for (int c = 0; c < WDOG && !done; c++) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state, R11 map
      rd(2'd0, 16'h0000, "R1");
      rd(2'd1, 16'hFFFF, "R1");
      rd(2'd2, 16'hFFFF, "R1");
      chk_irq(1'b0, "R1");
      rd(2'd3, 16'h0000, "R11");
      // R8 modulus write without overwrite keeps count
      wr(2'd1, 16'd5);
      rd(2'd2, 16'hFFFF, "R8");
      rd(2'd1, 16'd5, "R11");
      // R9 tick with timer disabled
      step();
      rd(2'd2, 16'hFFFF, "R9");
      // R7 overwrite load
      wr(2'd0, 16'h000B);
      wr(2'd1, 16'd3);
      rd(2'd2, 16'd3, "R7");
      // R9 enabled but no tick
      drive(1'b0, 1'b0, 2'd0, 16'h0, 1'b0);
      drive(1'b0, 1'b0, 2'd0, 16'h0, 1'b0);
      rd(2'd2, 16'd3, "R9");
      // R2 reload sequence 3,2,1,0,3
      step(); rd(2'd2, 16'd2, "R2");
      step(); rd(2'd2, 16'd1, "R2");
      step(); rd(2'd2, 16'd0, "R2");
      rd(2'd0, 16'h001B, "R4");
      chk_irq(1'b0, "R5");
      step(); rd(2'd2, 16'd3, "R2");
      // R6 writing flag bit 0 keeps it; R5 irq follows enable
      wr(2'd0, 16'h000F);
      rd(2'd0, 16'h001F, "R6");
      chk_irq(1'b1, "R5");
      wr(2'd0, 16'h001F);
      rd(2'd0, 16'h000F, "R6");
      chk_irq(1'b0, "R5");
      // R8 new modulus used at next reload
      wr(2'd0, 16'h0007);
      wr(2'd1, 16'd2);
      rd(2'd2, 16'd3, "R8");
      step(); step(); step();
      rd(2'd2, 16'd0, "R8");
      chk_irq(1'b1, "R4");
      step();
      rd(2'd2, 16'd2, "R8");
      wr(2'd0, 16'h0017);
      chk_irq(1'b0, "R6");
      // R3 free-running wrap
      wr(2'd0, 16'h0009);
      wr(2'd1, 16'd1);
      rd(2'd2, 16'd1, "R7");
      step();
      rd(2'd2, 16'd0, "R4");
      rd(2'd0, 16'h0019, "R4");
      step(); rd(2'd2, 16'hFFFF, "R3");
      step(); rd(2'd2, 16'hFFFE, "R3");
      // R10 count word is read-only
      wr(2'd2, 16'h1234);
      rd(2'd2, 16'hFFFE, "R10");
      // R9 disabled timer freezes
      wr(2'd0, 16'h0018);
      step(); step(); step();
      rd(2'd2, 16'hFFFE, "R9");
      rd(2'd0, 16'h0008, "R6");
      // R6 set wins over clear on the same edge
      wr(2'd1, 16'd1);
      wr(2'd0, 16'h0001);
      rd(2'd2, 16'd1, "R7");
      drive(1'b1, 1'b1, 2'd0, 16'h0011, 1'b1);
      rd(2'd0, 16'h0011, "R6");
      rd(2'd2, 16'd0, "R4");
      drive(1'b0, 1'b0, 2'd0, 16'h0, 1'b0);
      drive(1'b0, 1'b0, 2'd0, 16'h0, 1'b0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule